// File: doc/BRIEF.md
# Compare-Zero Branch Resolver

This unit settles the outcome of a conditional branch whose condition is the sign of one register, for a pipeline with a single branch delay slot. A request carries the branch's own address, the register value, the 16-bit word offset from the instruction, a condition selector, and three qualifier flags: link, likely, and whether the branch itself sits in a delay slot. One clock later the unit returns the next fetch address and a redirect-pending flag, a return address with a write enable meant for register 31, an annul flag for the delay-slot instruction, and an error flag for a branch found in a delay slot.

The register is read as a two's-complement number, so only its top bit decides the outcome, and zero counts as "greater or equal". All address arithmetic wraps modulo 2^64. A likely branch that falls through has no delay slot, so it annuls the next instruction and cannot trip the delay-slot error.

Top module: `br_resolver`

## Requirements
- R1: Results appear on the outputs in the cycle after a request (`br_valid_i` high at a rising edge sets `res_valid_o` for one cycle). In any cycle with `res_valid_o` low, every other output is zero.
- R2: Condition select `cmp_ge_i` = 0 means taken when bit 63 of `rs_val_i` is 1 (less than zero). `cmp_ge_i` = 1 means taken when bit 63 is 0, zero included.
- R3: A taken branch gives `target_o` = pc + 4 + (sign-extended offset shifted left by 2), wrapping modulo 2^64.
- R4: A non-likely branch that is not taken gives `target_o` = pc + 8, `pend_o` = 1 and `annul_o` = 0.
- R5: A likely branch that is not taken gives `annul_o` = 1, `pend_o` = 0 and `target_o` = pc + 8.
- R6: Every taken branch, likely or not, gives `pend_o` = 1 and `annul_o` = 0.
- R7: With `link_i` set, `link_we_o` = 1 and `link_data_o` = pc + 8 (mod 2^64), whether or not the branch is taken. With `link_i` clear, both are 0.
- R8: `slot_err_o` = 1 when `in_slot_i` is set and a delay slot follows (taken, or non-likely). For a likely branch that is not taken, it stays 0.
- R9: A synchronous active-low reset clears all outputs at the next rising edge, even while a request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_valid_i | input | 1 | Branch request strobe |
| pc_i | input | 64 | Address of the branch instruction |
| rs_val_i | input | 64 | Register operand under test |
| offset_i | input | 16 | Signed word offset from the instruction |
| cmp_ge_i | input | 1 | 0: less than zero, 1: greater or equal zero |
| link_i | input | 1 | Write return address to register 31 |
| likely_i | input | 1 | Annul the delay slot when not taken |
| in_slot_i | input | 1 | This branch sits in a delay slot |
| res_valid_o | output | 1 | Result strobe |
| target_o | output | 64 | Next fetch address after the branch |
| pend_o | output | 1 | Redirect to target after the delay slot |
| annul_o | output | 1 | Skip the delay-slot instruction |
| link_we_o | output | 1 | Register 31 write enable |
| link_data_o | output | 64 | Return address (pc + 8) |
| slot_err_o | output | 1 | Branch found in a delay slot |

## Verification
The vector table crosses the two conditions with operands at zero, at the most negative and most positive values, and at small values of each sign. This separates a sign-bit test from a magnitude test and shows on which side zero falls. Each condition is run with the likely and link flags on and off, so that annul versus pending is distinguished from taken versus not taken, and so that the link write is seen on both paths. Directed cases put the pc near the top of the address space and use the most negative offset to expose wrap and sign-extension errors, and they set the slot flag on a likely fall-through to confirm the error is suppressed.

// File: rtl/br_res_pkg.sv
// Package: shared types for the compare-zero branch resolver.
// Assumes: two's-complement operands; fixed 4-byte instruction size.
package br_res_pkg;

    // Condition selector encoding as seen on the cmp_ge_i pin.
    typedef enum logic {
        CMP_LTZ = 1'b0,
        CMP_GEZ = 1'b1
    } cmp_e;

    // Control outcome of one resolved branch.
    typedef struct packed {
        logic pend;
        logic annul;
        logic link_we;
        logic slot_err;
    } outcome_t;

endpackage

// File: rtl/br_sign_test.sv
// Module: br_sign_test
// Decides whether a sign-test branch is taken. Only the top bit of the
// operand matters; zero is treated as non-negative.
// Assumes: operand is two's complement of width DATA_W.
module br_sign_test
    import br_res_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] operand_i,
    input  cmp_e              cmp_i,
    output logic              taken_o
);
    localparam int SIGN_BIT = DATA_W - 1;

    logic is_neg;

    // Extract sign and apply the selected condition.
    always_comb begin
        is_neg = operand_i[SIGN_BIT];
        unique case (cmp_i)
            CMP_LTZ: taken_o = is_neg;
            CMP_GEZ: taken_o = !is_neg;
            default: taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target_gen.sv
// Module: br_target_gen
// Produces the taken target (pc + one instruction + scaled offset) and the
// sequential address past the delay slot (pc + two instructions).
// Assumes: arithmetic wraps at ADDR_W bits; INSTR_BYTES is a power of two.
module br_target_gen #(
    parameter int ADDR_W      = 64,
    parameter int OFF_W       = 16,
    parameter int INSTR_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] taken_tgt_o,
    output logic [ADDR_W-1:0] seq_tgt_o
);
    localparam int SCALE   = $clog2(INSTR_BYTES);
    localparam int EXT_W   = ADDR_W - OFF_W - SCALE;
    localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSTR_BYTES);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSTR_BYTES);

    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] next_pc;

    // Sign-extend the word offset and scale it to bytes.
    generate
        if (SCALE > 0) begin : g_scaled
            always_comb disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, {SCALE{1'b0}}};
        end else begin : g_unscaled
            always_comb disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
        end
    endgenerate

    // Address of the delay slot and the two candidate targets.
    always_comb begin
        next_pc     = pc_i + STEP1;
        taken_tgt_o = next_pc + disp;
        seq_tgt_o   = pc_i + STEP2;
    end
endmodule

// File: rtl/br_outcome.sv
// Module: br_outcome
// Turns the taken decision and the branch qualifiers into the control
// outcome: redirect pending, delay-slot annul, link write, slot error.
// Assumes: a not-taken likely branch has no delay slot.
module br_outcome
    import br_res_pkg::*;
(
    input  logic     taken_i,
    input  logic     likely_i,
    input  logic     link_i,
    input  logic     in_slot_i,
    output outcome_t out_o
);
    logic has_slot;

    // A delay slot follows unless a likely branch falls through.
    always_comb begin
        has_slot        = taken_i || !likely_i;
        out_o.pend      = has_slot;
        out_o.annul     = !has_slot;
        out_o.link_we   = link_i;
        out_o.slot_err  = has_slot && in_slot_i;
    end
endmodule

// File: rtl/br_resolver.sv
// Module: br_resolver (top)
// Resolves compare-against-zero branches with one delay slot. A request
// is registered; results are valid for one cycle afterwards, zero otherwise.
// Assumes: synchronous active-low reset; link target is register 31 (fixed
// by the consumer, only the data and enable are produced here).
module br_resolver
    import br_res_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int DATA_W      = 64,
    parameter int OFF_W       = 16,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] rs_val_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic              cmp_ge_i,
    input  logic              link_i,
    input  logic              likely_i,
    input  logic              in_slot_i,
    output logic              res_valid_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              pend_o,
    output logic              annul_o,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_data_o,
    output logic              slot_err_o
);
    localparam logic [ADDR_W-1:0] RET_OFS = ADDR_W'(2 * INSTR_BYTES);

    logic              taken;
    logic [ADDR_W-1:0] taken_tgt;
    logic [ADDR_W-1:0] seq_tgt;
    outcome_t          oc;
    logic [ADDR_W-1:0] tgt_sel;

    br_sign_test #(.DATA_W(DATA_W)) u_test (
        .operand_i (rs_val_i),
        .cmp_i     (cmp_e'(cmp_ge_i)),
        .taken_o   (taken)
    );

    br_target_gen #(
        .ADDR_W      (ADDR_W),
        .OFF_W       (OFF_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_tgt (
        .pc_i        (pc_i),
        .offset_i    (offset_i),
        .taken_tgt_o (taken_tgt),
        .seq_tgt_o   (seq_tgt)
    );

    br_outcome u_oc (
        .taken_i   (taken),
        .likely_i  (likely_i),
        .link_i    (link_i),
        .in_slot_i (in_slot_i),
        .out_o     (oc)
    );

    // Choose the fetch address from the decision.
    always_comb tgt_sel = taken ? taken_tgt : seq_tgt;

    // Register the result; idle cycles and reset drive every output to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !br_valid_i) begin
            res_valid_o <= 1'b0;
            target_o    <= '0;
            pend_o      <= 1'b0;
            annul_o     <= 1'b0;
            link_we_o   <= 1'b0;
            link_data_o <= '0;
            slot_err_o  <= 1'b0;
        end else begin
            res_valid_o <= 1'b1;
            target_o    <= tgt_sel;
            pend_o      <= oc.pend;
            annul_o     <= oc.annul;
            link_we_o   <= oc.link_we;
            link_data_o <= oc.link_we ? seq_tgt : '0;
            slot_err_o  <= oc.slot_err;
        end
    end

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid_i |=> res_valid_o); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> !(pend_o || annul_o || link_we_o || slot_err_o) && target_o == '0); // R1
    AST_ONE_OF_PEND_ANNUL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (pend_o != annul_o)); // R5
    AST_ANNUL_SEQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        annul_o |-> target_o == $past(pc_i) + RET_OFS); // R5
    AST_LINK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> link_data_o == $past(pc_i) + RET_OFS); // R7
    AST_ERR_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err_o |-> $past(in_slot_i) && pend_o); // R8
    AST_ANNUL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        annul_o |-> !slot_err_o); // R8
endmodule

// File: tb/sim_br_resolver.sv
`timescale 1ns/1ps
module sim_br_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid_i = 1'b0;
    logic [63:0] pc_i = '0;
    logic [63:0] rs_val_i = '0;
    logic [15:0] offset_i = '0;
    logic        cmp_ge_i = 1'b0;
    logic        link_i = 1'b0;
    logic        likely_i = 1'b0;
    logic        in_slot_i = 1'b0;
    logic        res_valid_o;
    logic [63:0] target_o;
    logic        pend_o;
    logic        annul_o;
    logic        link_we_o;
    logic [63:0] link_data_o;
    logic        slot_err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    br_resolver u0 (
        .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid_i), .pc_i(pc_i),
        .rs_val_i(rs_val_i), .offset_i(offset_i), .cmp_ge_i(cmp_ge_i),
        .link_i(link_i), .likely_i(likely_i), .in_slot_i(in_slot_i),
        .res_valid_o(res_valid_o), .target_o(target_o), .pend_o(pend_o),
        .annul_o(annul_o), .link_we_o(link_we_o), .link_data_o(link_data_o),
        .slot_err_o(slot_err_o)
    );

    typedef struct packed {
        logic [63:0] pc;
        logic [63:0] rs;
        logic [15:0] off;
        logic        ge;
        logic        lnk;
        logic        lkly;
        logic        slot;
        logic        exp_tk;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{64'h1000, 64'h8000_0000_0000_0000, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{64'h2000, 64'h0,                   16'h0020, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'h3000, 64'h0,                   16'hFFF0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{64'h4000, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{64'h5000, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0040, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{64'h6000, 64'h5,                   16'h0040, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{64'h7000, 64'hFFFF_FFFF_FFFF_FFFB, 16'h0100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{64'h8000, 64'h5,                   16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{64'h9000, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0008, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{64'hA000, 64'h3,                   16'h0008, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{64'hB000, 64'h3,                   16'h0008, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; return after the result edge.
    task automatic issue(input logic [63:0] pc, input logic [63:0] rs, input logic [15:0] off,
                         input logic ge, input logic lnk, input logic lkly, input logic slot);
        @(negedge clk);
        br_valid_i = 1'b1; pc_i = pc; rs_val_i = rs; offset_i = off;
        cmp_ge_i = ge; link_i = lnk; likely_i = lkly; in_slot_i = slot;
        @(negedge clk);
        br_valid_i = 1'b0;
    endtask

    task automatic check_vec(input vec_t v);
        logic [63:0] tgt;
        logic pend_e, annul_e, err_e;
        tgt = v.exp_tk ? v.pc + 64'd4 + {{46{v.off[15]}}, v.off, 2'b00} : v.pc + 64'd8;
        pend_e  = v.exp_tk || !v.lkly;
        annul_e = !pend_e;
        err_e   = v.slot && pend_e;
        chk(res_valid_o == 1'b1, "R1 res_valid", 64'(res_valid_o), 64'd1);
        chk(target_o == tgt, v.exp_tk ? "R2/R3 taken target" : "R2/R4 seq target", target_o, tgt);
        chk(pend_o == pend_e, v.exp_tk ? "R6 pend" : "R4 pend", 64'(pend_o), 64'(pend_e));
        chk(annul_o == annul_e, "R5 annul", 64'(annul_o), 64'(annul_e));
        chk(link_we_o == v.lnk, "R7 link_we", 64'(link_we_o), 64'(v.lnk));
        chk(link_data_o == (v.lnk ? v.pc + 64'd8 : 64'd0), "R7 link_data", link_data_o,
            v.lnk ? v.pc + 64'd8 : 64'd0);
        chk(slot_err_o == err_e, "R8 slot_err", 64'(slot_err_o), 64'(err_e));
    endtask

    task automatic check_idle(input string tag);
        chk(res_valid_o == 1'b0 && target_o == 64'd0 && !pend_o && !annul_o && !link_we_o
            && link_data_o == 64'd0 && !slot_err_o, tag, target_o, 64'd0);
    endtask

    initial begin
        vec_t d;
        repeat (3) @(negedge clk);
        check_idle("R9 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset");

        for (int i = 0; i < NV; i++) begin
            issue(VT[i].pc, VT[i].rs, VT[i].off, VT[i].ge, VT[i].lnk, VT[i].lkly, VT[i].slot);
            check_vec(VT[i]);
        end
        @(negedge clk);
        check_idle("R1 quiet after result");

        // R3 wrap: taken target crosses zero.
        d = '{64'hFFFF_FFFF_FFFF_FFFC, 64'h1, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
        issue(d.pc, d.rs, d.off, d.ge, d.lnk, d.lkly, d.slot);
        chk(target_o == 64'd0, "R3 wrap taken", target_o, 64'd0);
        chk(link_data_o == 64'd4, "R7 wrap link", link_data_o, 64'd4);
        // R4 wrap: sequential target crosses zero.
        issue(64'hFFFF_FFFF_FFFF_FFFC, 64'h1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(target_o == 64'd4, "R4 wrap seq", target_o, 64'd4);
        // R3 most negative offset.
        issue(64'h10, 64'h0, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(target_o == 64'hFFFF_FFFF_FFFE_0014, "R3 min offset", target_o, 64'hFFFF_FFFF_FFFE_0014);
        // R3 offset of minus one lands on the branch itself.
        issue(64'h1000, 64'h8000_0000_0000_0000, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(target_o == 64'h1000, "R3 self loop", target_o, 64'h1000);
        chk(pend_o == 1'b1 && annul_o == 1'b0, "R6 likely taken", 64'(pend_o), 64'd1);

        // R9: reset held while a request is presented.
        @(negedge clk);
        rst_n = 1'b0; br_valid_i = 1'b1; rs_val_i = 64'h0; cmp_ge_i = 1'b1; link_i = 1'b1;
        @(negedge clk);
        check_idle("R9 reset beats request");
        br_valid_i = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule